// File: doc/BRIEF.md
# Registered Integer ALU with Shift Carry

This block is the execute-stage arithmetic unit of a small pipelined processor. Each cycle it can take an operation code, two operands and a valid strobe. It computes the result and four condition flags combinationally and registers them. The registered values appear on the cycle after the strobe, together with a matching output valid. When no strobe arrives, the outputs keep their last values.

It supports addition, subtraction, the three bitwise operations, three shifts, a left rotate, and two 16x16 multiplies, one signed and one unsigned. Shift and rotate amounts are taken from all of operand B, not only its low bits. Right shifts report the last bit that leaves the low end in the carry flag. Shifts by the word width or more saturate: they do not wrap.

Top module: `alu_core`

Operation codes on `in_op`: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift left logical, 6 shift right logical, 7 shift right arithmetic, 8 rotate left, 9 signed multiply, 10 unsigned multiply, 11 to 15 unused.

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Result and flags change only on the edge that follows a valid strobe, and otherwise hold their values.
- R2: Add (op 0) returns A+B modulo 2^32, with carry set to the carry out of bit 31. Subtract (op 1) returns A-B, with carry set when A < B unsigned (borrow). For both, overflow is set when the signed result overflows.
- R3: AND, OR and XOR (ops 2, 3, 4) return the bitwise result, with carry and overflow cleared.
- R4: Shift left (op 5) by n, for 1 <= n <= 31, returns A<<n, and carry is bit 32-n of A (the last bit out of bit 31). When n is 32, the result is zero and carry is A[0]. When n is above 32, the result and carry are both zero.
- R5: Logical right shift (op 6) by n, for 1 <= n <= 31, returns A>>n, and carry is A[n-1]. When n is 32, the result is zero and carry is A[31]. When n is above 32, the result and carry are both zero.
- R6: Arithmetic right shift (op 7) by n, for 1 <= n <= 31, returns A shifted right with sign fill, and carry is A[n-1]. When n is 32 or more, every result bit equals A[31] and carry equals A[31].
- R7: Rotate left (op 8) rotates A by B modulo 32. When that amount is nonzero, carry is bit 0 of the result.
- R8: A shift or rotate whose amount is zero returns A unchanged with carry cleared. For the rotate, the amount is taken modulo 32, so B equal to 32 also counts as zero.
- R9: Signed multiply (op 9) returns the 32-bit product of A[15:0] and B[15:0], both read as two's complement.
- R10: Unsigned multiply (op 10) returns the 32-bit product of A[15:0] and B[15:0], both read as unsigned.
- R11: For every operation, zero is set when the 32-bit result is 0, and negative equals result bit 31. Overflow is cleared for every operation other than add and subtract.
- R12: Unused codes 11 to 15 return a zero result, with carry and overflow cleared.
- R13: While reset is active, `out_valid`, the result and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B, also the shift or rotate amount |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 32 | Registered result |
| out_zero | output | 1 | Result is zero |
| out_carry | output | 1 | Carry, borrow or shift-out bit |
| out_neg | output | 1 | Result bit 31 |
| out_ovf | output | 1 | Signed overflow (add and subtract only) |

## Verification
The assertions run on every cycle. They check the one-cycle valid latency and that the outputs hold between strobes. They check that zero and negative follow the registered result, and that overflow is clear for every operation other than add and subtract. They also check the saturated right shifts and the zero-amount shift rule. The carry rules at amounts 1, 31, 32 and 33, the add and subtract borrow and overflow corners, the two multiply sign readings, and rotate wrap-around can only be shown by the bench's scenarios. The bench checks these against its behavioural reference model.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_ASR  = 4'd7,
        OP_ROL  = 4'd8,
        OP_MULS = 4'd9,
        OP_MULU = 4'd10
    } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   sum;

    always_comb begin
        b_eff = b ^ {W{sub}};
        sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        res   = sum[W-1:0];
        // borrow on subtract is the inverted carry out
        carry = sub ? ~sum[W] : sum[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_shifter.sv
import alu_pkg::*;

module alu_shifter #(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         carry
);
    localparam int AW = $clog2(W + 2);
    localparam int RW = $clog2(W);
    localparam logic [AW-1:0] AMT_SAT = AW'(W + 1);

    logic [AW-1:0]   amt;
    logic [RW-1:0]   rot;
    logic [W:0]      ext_l;
    logic [W:0]      ext_r;
    logic [W:0]      ext_s;
    logic [2*W-1:0]  dbl;

    always_comb begin
        // amounts past W+1 behave like W+1: everything has left the word
        amt   = (b > W'(W + 1)) ? AMT_SAT : b[AW-1:0];
        rot   = b[RW-1:0];
        ext_l = {1'b0, a} << amt;
        ext_r = {a, 1'b0} >> amt;
        ext_s = $signed({a, 1'b0}) >>> amt;
        dbl   = {a, a} << rot;
        res   = '0;
        carry = 1'b0;
        case (op)
            OP_SHL: begin
                res   = ext_l[W-1:0];
                carry = ext_l[W];
            end
            OP_SHR: begin
                res   = ext_r[W:1];
                carry = ext_r[0];
            end
            OP_ASR: begin
                res   = ext_s[W:1];
                carry = ext_s[0];
            end
            OP_ROL: begin
                res   = dbl[2*W-1:W];
                carry = (rot != '0) ? dbl[W] : 1'b0;
            end
            default: begin
                res   = '0;
                carry = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu_mul16.sv
module alu_mul16 #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    output logic [W-1:0] prod
);
    localparam int HW = W / 2;

    logic signed [W-1:0] p_s;
    logic        [W-1:0] p_u;

    always_comb begin
        p_s  = W'($signed(a[HW-1:0])) * W'($signed(b[HW-1:0]));
        p_u  = {{HW{1'b0}}, a[HW-1:0]} * {{HW{1'b0}}, b[HW-1:0]};
        prod = is_signed ? p_s : p_u;
    end
endmodule

// File: rtl/alu_core.sv
import alu_pkg::*;

module alu_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_result,
    output logic         out_zero,
    output logic         out_carry,
    output logic         out_neg,
    output logic         out_ovf
);
    alu_op_e      op;
    logic [W-1:0] as_res, sh_res, mul_res, nxt_res;
    logic         as_c, as_v, sh_c, nxt_c, nxt_v;

    assign op = alu_op_e'(in_op);

    alu_addsub #(.W(W)) u_addsub (
        .a(in_a), .b(in_b), .sub(op == OP_SUB),
        .res(as_res), .carry(as_c), .ovf(as_v)
    );

    alu_shifter #(.W(W)) u_shift (
        .op(op), .a(in_a), .b(in_b), .res(sh_res), .carry(sh_c)
    );

    alu_mul16 #(.W(W)) u_mul (
        .a(in_a), .b(in_b), .is_signed(op == OP_MULS), .prod(mul_res)
    );

    always_comb begin
        nxt_res = '0;
        nxt_c   = 1'b0;
        nxt_v   = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                nxt_res = as_res;
                nxt_c   = as_c;
                nxt_v   = as_v;
            end
            OP_AND: nxt_res = in_a & in_b;
            OP_OR:  nxt_res = in_a | in_b;
            OP_XOR: nxt_res = in_a ^ in_b;
            OP_SHL, OP_SHR, OP_ASR, OP_ROL: begin
                nxt_res = sh_res;
                nxt_c   = sh_c;
            end
            OP_MULS, OP_MULU: nxt_res = mul_res;
            default: nxt_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_zero   <= 1'b0;
            out_carry  <= 1'b0;
            out_neg    <= 1'b0;
            out_ovf    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= nxt_res;
                out_zero   <= (nxt_res == '0);
                out_carry  <= nxt_c;
                out_neg    <= nxt_res[W-1];
                out_ovf    <= nxt_v;
            end
        end
    end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [3:0]   in_op,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input logic         out_valid,
    input logic [W-1:0] out_result,
    input logic         out_zero,
    input logic         out_carry,
    input logic         out_neg,
    input logic         out_ovf
);
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry)));
    assert_zero_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_zero == (out_result == '0)));
    assert_neg_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_neg == out_result[W-1]));
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > 4'd1) |=> !out_ovf);
    assert_shr_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd6 && in_b >= W) |=> (out_result == '0));
    assert_asr_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd7 && in_b >= W) |=>
            (out_result == {W{$past(in_a[W-1])}} && out_carry == $past(in_a[W-1])));
    assert_zero_amount_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= 4'd5 && in_op <= 4'd7 && in_b == '0) |=>
            (out_result == $past(in_a) && !out_carry));
    assert_unused_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > 4'd10) |=> (out_result == '0 && !out_carry));
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
    .out_zero(out_zero), .out_carry(out_carry), .out_neg(out_neg), .out_ovf(out_ovf)
);

// File: tb/alu_core_tb.sv
module alu_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [31:0] in_a = '0, in_b = '0;
    logic        out_valid, out_zero, out_carry, out_neg, out_ovf;
    logic [31:0] out_result;

    int errors = 0;
    int checks = 0;

    logic        e_valid = 1'b0;
    logic [31:0] e_res = '0;
    logic        e_z = 1'b0, e_c = 1'b0, e_n = 1'b0, e_v = 1'b0;
    string       e_tag = "R13";

    always #5 clk = ~clk;

    alu_core u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
        .out_zero(out_zero), .out_carry(out_carry), .out_neg(out_neg), .out_ovf(out_ovf)
    );

    // behavioural reference: returns {z,c,n,v,result}
    function automatic logic [35:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        logic [31:0] r = 0;
        logic c = 0, v = 0;
        longint sa, sb, sr;
        int n;
        n = (b > 40) ? 40 : int'(b);
        case (op)
            0: begin
                r = a + b; c = ({1'b0, a} + {1'b0, b}) > 33'hFFFFFFFF;
                sa = longint'($signed(a)); sb = longint'($signed(b)); sr = sa + sb;
                v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            1: begin
                r = a - b; c = a < b;
                sa = longint'($signed(a)); sb = longint'($signed(b)); sr = sa - sb;
                v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: begin r = a; for (int i = 0; i < n; i++) begin c = r[31]; r = r << 1; end end
            6: begin r = a; for (int i = 0; i < n; i++) begin c = r[0]; r = r >> 1; end end
            7: begin r = a; for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end end
            8: begin
                r = a;
                for (int i = 0; i < int'(b % 32); i++) r = {r[30:0], r[31]};
                c = (b % 32 != 0) ? r[0] : 1'b0;
            end
            9: begin
                sr = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
                r = sr[31:0];
            end
            10: begin
                sr = longint'(a[15:0]) * longint'(b[15:0]);
                r = sr[31:0];
            end
            default: r = 0;
        endcase
        return {r == 0, c, r[31], v, r};
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== e_valid || out_result !== e_res || out_zero !== e_z ||
            out_carry !== e_c || out_neg !== e_n || out_ovf !== e_v) begin
            errors++;
            $display("FAIL %s: got v=%b res=%h zcnv=%b%b%b%b exp v=%b res=%h zcnv=%b%b%b%b",
                     e_tag, out_valid, out_result, out_zero, out_carry, out_neg, out_ovf,
                     e_valid, e_res, e_z, e_c, e_n, e_v);
        end
    endtask

    // drive one cycle; the result of the previous cycle is checked first
    task automatic step(input logic vld, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
        logic [35:0] m;
        @(negedge clk);
        compare();
        in_valid = vld; in_op = op; in_a = a; in_b = b;
        e_valid = vld;
        e_tag = tag;
        if (vld) begin
            m = model(op, a, b);
            {e_z, e_c, e_n, e_v, e_res} = m;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare();                              // R13 reset state
        rst_n = 1'b1;
        // R2 add/subtract corners
        step(1, 0, 32'hFFFFFFFF, 32'd1, "R2 add carry");
        step(1, 0, 32'h7FFFFFFF, 32'd1, "R2 add overflow");
        step(1, 1, 32'd3, 32'd5, "R2 sub borrow");
        step(1, 1, 32'h80000000, 32'd1, "R2 sub overflow");
        step(1, 1, 32'd9, 32'd9, "R2 sub zero R11");
        // R3 logic
        step(1, 2, 32'hF0F0FF00, 32'hFF00F0F0, "R3 and");
        step(1, 3, 32'h80000000, 32'h1, "R3 or R11");
        step(1, 4, 32'hAAAA5555, 32'hAAAA5555, "R3 xor");
        // R4 shift left boundaries
        step(1, 5, 32'h40000001, 32'd1, "R4 shl 1");
        step(1, 5, 32'h00000003, 32'd31, "R4 shl 31");
        step(1, 5, 32'h00000001, 32'd32, "R4 shl 32");
        step(1, 5, 32'hFFFFFFFF, 32'd33, "R4 shl 33");
        // R5 logical right
        step(1, 6, 32'h00000002, 32'd2, "R5 shr 2");
        step(1, 6, 32'h80000000, 32'd31, "R5 shr 31");
        step(1, 6, 32'h80000000, 32'd32, "R5 shr 32");
        step(1, 6, 32'hFFFFFFFF, 32'hFFFFFFFF, "R5 shr huge");
        // R6 arithmetic right
        step(1, 7, 32'h80000010, 32'd4, "R6 asr 4");
        step(1, 7, 32'h80000000, 32'd32, "R6 asr 32");
        step(1, 7, 32'h7FFFFFFF, 32'h10000, "R6 asr huge pos");
        step(1, 7, 32'hC0000000, 32'h80000000, "R6 asr huge neg");
        // R7 rotate
        step(1, 8, 32'h80000001, 32'd1, "R7 rol 1");
        step(1, 8, 32'h12345678, 32'd36, "R7 rol mod");
        // R8 zero amounts
        step(1, 5, 32'h80000001, 32'd0, "R8 shl 0");
        step(1, 6, 32'h00000001, 32'd0, "R8 shr 0");
        step(1, 7, 32'h80000001, 32'd0, "R8 asr 0");
        step(1, 8, 32'hDEADBEEF, 32'd32, "R8 rol 32");
        // R9 / R10 multiplies
        step(1, 9, 32'h0000FFFF, 32'h00000002, "R9 muls neg");
        step(1, 9, 32'hABCD8000, 32'h55558000, "R9 muls min");
        step(1, 10, 32'h0000FFFF, 32'h0000FFFF, "R10 mulu max");
        step(1, 10, 32'hFFFF0003, 32'hFFFF0004, "R10 mulu hi ignored");
        // R12 unused codes
        step(1, 11, 32'h12345678, 32'h1, "R12 op11");
        step(1, 15, 32'hFFFFFFFF, 32'h40, "R12 op15");
        // R1 hold while idle
        step(1, 0, 32'd100, 32'd23, "R1 load");
        step(0, 1, 32'hFFFF, 32'h1, "R1 idle");
        step(0, 5, 32'h1, 32'h1, "R1 idle2");
        step(1, 4, 32'hFF, 32'h0F, "R1 resume");
        // mixed traffic, all codes, several amount ranges
        for (int k = 0; k < 400; k++) begin
            logic [31:0] rb;
            rb = $urandom;
            if (k % 3 == 0) rb = rb % 40;
            step((k % 7) != 3, 4'($urandom % 16), $urandom, rb, "R11 mixed");
        end
        step(0, 0, 0, 0, "R1 drain");
        @(negedge clk);
        compare();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule